// File: doc/BRIEF.md
# Return Address Stack with Fill Watermark Interrupt

This block is a hardware last-in first-out store for return addresses. A sequencer pushes the next program address when it takes a call or an interrupt and pops it on the matching return. The top entry is always visible on an output, together with the current number of entries held.

Software can keep this stack from running dry or spilling over before either happens. The block watches its occupancy against a low mark and a high mark. When the occupancy moves into the near-empty zone or the near-full zone, and the enable input is set, it latches a level interrupt. A handler can then save entries to memory or restore them from memory, and writes a clear strobe when it is done. Hard errors are kept apart from the interrupt: a push into a full stack and a pop from an empty stack each raise a flag of its own, and that flag stays set until reset.

The default configuration holds 33 entries of 16 bits. It counts as near empty below 3 entries and as near full above 28 entries. Each of these values is a parameter, so the same block can serve as a stack of another depth.

Top module: `pc_return_stack`

## Requirements
- R1: While reset is asserted (rst_n low, asynchronous) and after it is released, fill is 0, top_data is 0, and overflow, underflow and level_irq are all 0.
- R2: A push without a pop on a stack that is not full stores push_data, and fill rises by one at the next clock edge. A pop without a push on a stack that is not empty lowers fill by one. top_data always shows the most recently stored entry that has not yet been popped, and it reads 0 when fill is 0.
- R3: A push without a pop while fill equals DEPTH (33) sets overflow. fill and every stored entry stay unchanged.
- R4: A pop while fill is 0 sets underflow and fill stays 0. This also applies when push is high in the same cycle, and in that case nothing is stored.
- R5: Push and pop together on a stack that is not empty overwrite the top entry with push_data and leave fill unchanged.
- R6: When an operation takes fill from 28 or fewer to more than 28, and irq_en is high in that cycle, level_irq is 1 from the next clock edge.
- R7: When an operation takes fill from 3 or more to fewer than 3, and irq_en is high in that cycle, level_irq is 1 from the next clock edge.
- R8: Pushes and pops that keep fill inside the same zone do not set level_irq again once it has been cleared.
- R9: A crossing made while irq_en is low does not set level_irq. irq_clr clears level_irq at the next edge, and a new crossing in the same cycle as irq_clr wins over the clear.
- R10: overflow and underflow stay set until reset, whatever later pushes or pops occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| push | input | 1 | Push strobe |
| pop | input | 1 | Pop strobe |
| push_data | input | WIDTH | Address to store |
| irq_en | input | 1 | Enables latching of the watermark interrupt |
| irq_clr | input | 1 | Clears the latched watermark interrupt |
| top_data | output | WIDTH | Most recent entry, 0 when empty |
| fill | output | $clog2(DEPTH+1) | Number of entries held |
| level_irq | output | 1 | Latched watermark interrupt |
| overflow | output | 1 | Sticky push-when-full error |
| underflow | output | 1 | Sticky pop-when-empty error |

## Verification
Directed runs fill the stack all the way to the top and drain it all the way to the bottom, so each watermark crossing is tried with the enable set and with it clear. These runs separate an edge-triggered latch from one that retriggers on every operation, and they show which of clear and set wins. Repeated pushes into a full stack and pops from an empty one show that the error flags stay set and that the contents are left alone. Simultaneous push and pop, both on an empty stack and on a filled one, separate the replace-top case from the underflow case. Random phases that lean toward pushes or toward pops then sweep fill across both zones many times, with random clears, and a mid-run reset shows that the sticky flags are released.

// File: rtl/pc_return_stack.sv
module pc_return_stack #(
  parameter int DEPTH     = 33,
  parameter int WIDTH     = 16,
  parameter int LOW_MARK  = 3,
  parameter int HIGH_MARK = 28,
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] push_data,
  input  logic             irq_en,
  input  logic             irq_clr,
  output logic [WIDTH-1:0] top_data,
  output logic [CW-1:0]    fill,
  output logic             level_irq,
  output logic             overflow,
  output logic             underflow
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [CW-1:0]    next_fill;
  logic [CW-1:0]    top_idx;
  logic             full, empty;
  logic             do_push, do_pop, do_swap;
  logic             enter_low, enter_high;

  assign full    = (fill == CW'(DEPTH));
  assign empty   = (fill == '0);
  assign top_idx = fill - CW'(1);

  assign do_push = push & ~pop & ~full;
  assign do_pop  = pop & ~push & ~empty;
  assign do_swap = push & pop & ~empty;

  assign next_fill = do_push ? fill + CW'(1) :
                     do_pop  ? fill - CW'(1) : fill;

  assign enter_low  = (next_fill < CW'(LOW_MARK))  & ~(fill < CW'(LOW_MARK));
  assign enter_high = (next_fill > CW'(HIGH_MARK)) & ~(fill > CW'(HIGH_MARK));

  assign top_data = empty ? '0 : mem[top_idx];

  always_ff @(posedge clk) begin
    if (do_push) mem[fill]    <= push_data;
    if (do_swap) mem[top_idx] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill      <= '0;
      level_irq <= 1'b0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      fill      <= next_fill;
      level_irq <= (level_irq & ~irq_clr) | (irq_en & (enter_low | enter_high));
      overflow  <= overflow  | (push & ~pop & full);
      underflow <= underflow | (pop & empty);
    end
  end

endmodule

module pc_return_stack_chk #(
  parameter int DEPTH     = 33,
  parameter int WIDTH     = 16,
  parameter int LOW_MARK  = 3,
  parameter int HIGH_MARK = 28,
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             push,
  input logic             pop,
  input logic [WIDTH-1:0] push_data,
  input logic             irq_en,
  input logic             irq_clr,
  input logic [WIDTH-1:0] top_data,
  input logic [CW-1:0]    fill,
  input logic             level_irq,
  input logic             overflow,
  input logic             underflow
);

  a_r2_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));

  a_r2_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && fill != CW'(DEPTH)) |=> (fill == $past(fill) + CW'(1)) && (top_data == $past(push_data)));

  a_r3_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && fill == CW'(DEPTH)) |=> overflow && fill == CW'(DEPTH) && $stable(top_data));

  a_r4_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && fill == '0) |=> underflow && fill == '0);

  a_r5_swap_keeps_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && fill != '0) |=> $stable(fill) && (top_data == $past(push_data)));

  a_r9_rise_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(level_irq) |-> $past(irq_en));

  a_r8_rise_needs_move: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(level_irq) |-> !$stable(fill));

  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  a_r10_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);

  always_comb if (rst_n && fill == '0) a_r2_empty_top_zero: assert (top_data == '0);

endmodule

bind pc_return_stack pc_return_stack_chk #(
  .DEPTH(DEPTH), .WIDTH(WIDTH), .LOW_MARK(LOW_MARK), .HIGH_MARK(HIGH_MARK)
) u_chk (.*);

// File: tb/tb_pc_return_stack.sv
`timescale 1ns/1ps
module tb_pc_return_stack;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push = 1'b0, pop = 1'b0, irq_en = 1'b0, irq_clr = 1'b0;
  logic [15:0] push_data = '0;
  logic [15:0] top_data;
  logic [5:0]  fill;
  logic        level_irq, overflow, underflow;

  int checks = 0;
  int errors = 0;

  logic [15:0] mstk [33];
  int          mcnt = 0;
  bit          mov = 0, mun = 0, mirq = 0;

  always #10 clk = ~clk;

  pc_return_stack dut (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .push_data(push_data),
    .irq_en(irq_en), .irq_clr(irq_clr), .top_data(top_data), .fill(fill),
    .level_irq(level_irq), .overflow(overflow), .underflow(underflow)
  );

  function automatic logic [15:0] exp_top();
    return (mcnt == 0) ? 16'h0 : mstk[mcnt-1];
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "fill", int'(fill), mcnt);
    chk(tag, "top_data", int'(top_data), int'(exp_top()));
    chk(tag, "overflow", int'(overflow), int'(mov));
    chk(tag, "underflow", int'(underflow), int'(mun));
    chk(tag, "level_irq", int'(level_irq), int'(mirq));
  endtask

  task automatic model(bit pu, bit po, logic [15:0] d, bit en, bit cl);
    int oc = mcnt;
    int nc = mcnt;
    bit enter;
    if (pu && !po) begin
      if (oc == 33) mov = 1; else begin mstk[oc] = d; nc = oc + 1; end
    end else if (po && !pu) begin
      if (oc == 0) mun = 1; else nc = oc - 1;
    end else if (pu && po) begin
      if (oc == 0) mun = 1; else mstk[oc-1] = d;
    end
    enter = ((nc < 3) && !(oc < 3)) || ((nc > 28) && !(oc > 28));
    mirq = (mirq && !cl) || (en && enter);
    mcnt = nc;
  endtask

  task automatic step(string tag, bit pu, bit po, logic [15:0] d, bit en, bit cl);
    @(negedge clk);
    push = pu; pop = po; push_data = d; irq_en = en; irq_clr = cl;
    @(posedge clk);
    #1;
    model(pu, po, d, en, cl);
    compare(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; push = 0; pop = 0; irq_en = 0; irq_clr = 0;
    repeat (2) @(negedge clk);
    mcnt = 0; mov = 0; mun = 0; mirq = 0;
    compare("R1 in reset");
    rst_n = 1'b1;
    @(posedge clk); #1;
    compare("R1 after release");
  endtask

  initial begin
    #(20ns * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();

    // R4 pop on empty, and R5 push+pop on empty counts as underflow
    step("R4 pop empty", 0, 1, 16'h1111, 1, 0);
    do_reset();
    step("R4 R5 swap on empty", 1, 1, 16'h2222, 1, 0);
    do_reset();

    // R2 fill up; R6 crossing 28->29 with enable
    for (int i = 0; i < 33; i++)
      step(i == 28 ? "R6 high crossing" : "R2 push", 1, 0, 16'hA000 + 16'(i), 1, 0);
    // R9 clear, then R8 no retrigger while staying high
    step("R9 clear", 0, 0, 0, 1, 1);
    step("R8 pop in zone", 0, 1, 0, 1, 0);
    step("R8 push in zone", 1, 0, 16'hBEEF, 1, 0);
    // R3 overflow, contents kept
    step("R3 push full", 1, 0, 16'hDEAD, 1, 0);
    step("R3 R10 push full again", 1, 0, 16'hDEAD, 1, 0);
    // R5 replace top
    step("R5 swap", 1, 1, 16'h5A5A, 1, 0);
    step("R9 clear", 0, 0, 0, 1, 1);
    // R2 LIFO drain; R7 crossing 3->2
    for (int i = 0; i < 33; i++)
      step(mcnt == 3 ? "R7 low crossing" : "R2 pop", 0, 1, 0, 1, 0);
    step("R4 R10 pop empty", 0, 1, 0, 1, 0);
    step("R10 push after error", 1, 0, 16'h0042, 1, 1);
    do_reset();

    // R9 crossing with enable low does not latch
    for (int i = 0; i < 30; i++) step("R9 disabled crossing", 1, 0, 16'(i), 0, 0);
    for (int i = 0; i < 2; i++) step("R9 disabled hold", 0, 1, 0, 0, 0);
    // R9 set wins over clear: re-enter high zone with clear asserted
    step("R9 set beats clear", 1, 0, 16'h7777, 1, 1);
    step("R9 clear alone", 0, 0, 0, 1, 1);
    do_reset();

    // Random phases sweeping both zones
    for (int ph = 0; ph < 10; ph++) begin
      int bias = (ph % 2 == 0) ? 75 : 25;
      for (int k = 0; k < 400; k++) begin
        int r = $urandom_range(99);
        bit pu = (r < bias);
        bit po = !pu || ($urandom_range(9) == 0);
        step("R2 R5 R6 R7 R8 random", pu, po, 16'($urandom), $urandom_range(7) != 0,
             $urandom_range(7) == 0);
      end
      if (ph == 5) do_reset();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule